// File: doc/BRIEF.md
# Serial Management Register Device

This block is the device side of a two-wire serial management link. It runs on the management clock, reads one bit from the shared data line on every rising edge, and turns the line around to send read data back. Each frame has 16 bits of header and turnaround overhead, followed by one 16-bit data word. A frame's header selects a port address, a device address and an operation. The operation either loads the address pointer that the block keeps for each device, writes the register at that pointer, reads it, or reads it and then moves the pointer on.

Only device 1 holds registers. Its lower address half (0x0000 to 0x7FFF) is reserved for registers defined by the standard. Two of them exist here: a control register at address 0 and a read-only identifier at address 1. The upper half (0x8000 to 0xFFFF) is vendor space, and it holds a bank-select register plus a data-window register. The window reaches one of several per-subcarrier registers, and the bank-select value picks which one. This indirect path gives access to more per-subcarrier storage than fixed 16-bit addressing would allow. Bit 15 of the control register starts an internal reset of the register contents, and that bit then clears itself.

The data path is a serial line that moves exactly one bit per clock. There is no valid/ready handshake and no back-pressure. The station sets the pace, and the block keeps up with every edge. The port address and all other controls are plain pins.

Top module: `mgmt_regdev`

## Requirements
- R1: A start code is accepted only when at least PRE_LEN (default 32) ones were sampled on `md_in` since the last zero or the end of the last frame. A frame without that preamble has no effect.
- R2: Frame bit order is as follows: start code 00, opcode (2 bits), port (5 bits), device (5 bits), turnaround (2 bits), data (16 bits, MSB first). Opcodes are 00 = load address pointer, 01 = write, 11 = read, 10 = read then increment.
- R3: A frame whose port field differs from `my_port` changes no pointer and no register, and `md_oe` stays 0 throughout it.
- R4: On a read, `md_oe` is 0 for turnaround bit 14. The block drives 0 for bit 15, then data bits 16 to 31 MSB first, and releases the line after bit 31.
- R5: A write stores the word at the addressed device's pointer. Neither a write nor a plain read moves the pointer.
- R6: A read-then-increment returns the data and then adds 1 to that device's pointer. 0xFFFF wraps to 0x0000.
- R7: Any other device, and any unimplemented address, reads as 0 and ignores writes. The identifier at device 1 address 1 reads ID_WORD (default 0x2A5C) and ignores writes.
- R8: Each of the 32 device addresses has its own pointer. Loading one pointer leaves the others unchanged.
- R9: Device 1 address 0x8000 holds the bank select. Only its low IDX_W bits (default 3) are kept, and the upper bits read 0. Address 0x8001 reads and writes the subcarrier register chosen by the bank select.
- R10: Writing 1 to device 1 address 0 bit 15 holds all registers at their defaults for RST_CYCLES clocks. Bit 15 reads 1 during that time and 0 afterwards.
- R11: After `rst_n` is asserted, `md_oe` is 0, all pointers are 0, the control register reads CTRL_RST (default 0x1040) and the bank select and subcarrier registers read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mdc | input | 1 | Management clock; every action happens on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| my_port | input | 5 | Port address this device answers to |
| md_in | input | 1 | Sampled value of the shared data line |
| md_out | output | 1 | Value driven onto the data line |
| md_oe | output | 1 | Drive enable for the data line (1 = block drives) |

## Verification
The embedded properties check several rules on every cycle. No frame starts without a full preamble. The drive enable only rises inside a selected frame, and the first driven bit is a zero. The line is released after the last data bit. A read-then-increment moves the visible pointer by exactly one. Unimplemented devices read zero. The soft reset ends after its counter runs out, with the registers at their defaults. The directed scenarios are the only way to show end-to-end effects: data round trips through the window, pointer independence across devices, ignored writes to the identifier, a mismatched port, and the value of bit 15 while the reset is still in progress.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  localparam int WORD_W = 16;
  localparam int DEV_W  = 5;
  localparam int PORT_W = 5;
  localparam int FRAME_BITS = 32;

  typedef enum logic [1:0] {
    OP_ADDR  = 2'b00,
    OP_WRITE = 2'b01,
    OP_RDINC = 2'b10,
    OP_READ  = 2'b11
  } mop_e;
endpackage

// File: rtl/mgmt_frame_rx.sv
module mgmt_frame_rx
  import mgmt_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              md_in,
  input  logic [PORT_W-1:0] my_port,
  input  logic [WORD_W-1:0] rdata,
  output logic [DEV_W-1:0]  cur_dev,
  output logic              ptr_load,
  output logic              ptr_inc,
  output logic              reg_we,
  output logic [WORD_W-1:0] wdata,
  output logic              md_out,
  output logic              md_oe
);
  localparam int ONES_W = $clog2(PRE_LEN + 1);
  localparam int HDR_W  = 2 + PORT_W + DEV_W;

  logic [ONES_W-1:0] ones_q;
  logic              in_frame_q;
  logic [4:0]        bit_q;
  logic [HDR_W-1:0]  hdr_q;
  logic [WORD_W-1:0] dsr_q, tx_q;
  logic              sel_q, drv_q, out_q;
  mop_e              op_q;
  logic [DEV_W-1:0]  dev_q;

  logic              pre_ok, last_bit, is_rd;
  logic [HDR_W-1:0]  hdr_nx;

  assign pre_ok   = (ones_q == ONES_W'(PRE_LEN));
  assign hdr_nx   = {hdr_q[HDR_W-2:0], md_in};
  assign wdata    = {dsr_q[WORD_W-2:0], md_in};
  assign last_bit = in_frame_q && (bit_q == 5'd31);
  assign is_rd    = (op_q == OP_READ) || (op_q == OP_RDINC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q     <= '0;
      in_frame_q <= 1'b0;
      bit_q      <= '0;
      hdr_q      <= '0;
      dsr_q      <= '0;
      tx_q       <= '0;
      sel_q      <= 1'b0;
      drv_q      <= 1'b0;
      out_q      <= 1'b0;
      op_q       <= OP_ADDR;
      dev_q      <= '0;
    end else if (!in_frame_q) begin
      if (md_in) begin
        if (!pre_ok) ones_q <= ones_q + 1'b1;
      end else if (pre_ok) begin
        in_frame_q <= 1'b1;
        bit_q      <= 5'd1;
        ones_q     <= '0;
        sel_q      <= 1'b0;
      end else begin
        ones_q <= '0;
      end
    end else begin
      bit_q <= bit_q + 1'b1;
      if (bit_q == 5'd1 && md_in) begin
        in_frame_q <= 1'b0;
        ones_q     <= ONES_W'(1);
      end
      if (bit_q >= 5'd2 && bit_q <= 5'd13) hdr_q <= hdr_nx;
      if (bit_q == 5'd13) begin
        op_q  <= mop_e'(hdr_nx[HDR_W-1 -: 2]);
        sel_q <= (hdr_nx[DEV_W +: PORT_W] == my_port);
        dev_q <= hdr_nx[DEV_W-1:0];
      end
      if (bit_q >= 5'd16) dsr_q <= wdata;
      if (bit_q == 5'd14 && sel_q && is_rd) begin
        drv_q <= 1'b1;
        out_q <= 1'b0;
        tx_q  <= rdata;
      end
      if (bit_q >= 5'd15 && drv_q) begin
        out_q <= tx_q[WORD_W-1];
        tx_q  <= {tx_q[WORD_W-2:0], 1'b0};
      end
      if (bit_q == 5'd31) begin
        in_frame_q <= 1'b0;
        drv_q      <= 1'b0;
        out_q      <= 1'b0;
      end
    end
  end

  assign cur_dev  = dev_q;
  assign ptr_load = last_bit && sel_q && (op_q == OP_ADDR);
  assign reg_we   = last_bit && sel_q && (op_q == OP_WRITE);
  assign ptr_inc  = last_bit && sel_q && (op_q == OP_RDINC);
  assign md_out   = out_q;
  assign md_oe    = drv_q;

  assert_pre_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_frame_q && !pre_ok) |=> !in_frame_q);
  assert_drive_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    drv_q |-> (sel_q && in_frame_q));
  assert_ta_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_q) |-> (out_q == 1'b0 && bit_q == 5'd15));
  assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    last_bit |=> !drv_q);
endmodule

// File: rtl/mgmt_addr_ptrs.sv
module mgmt_addr_ptrs
  import mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DEV_W-1:0]  dev,
  input  logic              load,
  input  logic              inc,
  input  logic [WORD_W-1:0] load_val,
  output logic [WORD_W-1:0] ptr
);
  localparam int N_DEV = 1 << DEV_W;

  logic [WORD_W-1:0] ptr_q [N_DEV];

  for (genvar g = 0; g < N_DEV; g++) begin : g_ptr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         ptr_q[g] <= '0;
      else if (load && dev == DEV_W'(g))  ptr_q[g] <= load_val;
      else if (inc && dev == DEV_W'(g))   ptr_q[g] <= ptr_q[g] + 1'b1;
    end
  end

  assign ptr = ptr_q[dev];

  assert_inc_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> (ptr == $past(ptr) + 16'd1));
endmodule

// File: rtl/mgmt_reg_bank.sv
module mgmt_reg_bank
  import mgmt_pkg::*;
#(
  parameter int                IDX_W      = 3,
  parameter int                RST_CYCLES = 8,
  parameter logic [WORD_W-1:0] ID_WORD    = 16'h2A5C,
  parameter logic [WORD_W-1:0] CTRL_RST   = 16'h1040,
  parameter logic [DEV_W-1:0]  MY_DEV     = 5'd1,
  parameter logic [WORD_W-1:0] VND_IDX    = 16'h8000,
  parameter logic [WORD_W-1:0] VND_WIN    = 16'h8001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DEV_W-1:0]  dev,
  input  logic [WORD_W-1:0] addr,
  input  logic              we,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  localparam int NSC  = 1 << IDX_W;
  localparam int RC_W = $clog2(RST_CYCLES + 1);

  logic [WORD_W-2:0] ctrl_q;
  logic [IDX_W-1:0]  idx_q;
  logic              busy_q;
  logic [RC_W-1:0]   rcnt_q;
  logic [WORD_W-1:0] bank_w [NSC];

  logic mine, wr_ok, wr_ctrl, wr_idx, wr_win;
  assign mine    = (dev == MY_DEV);
  assign wr_ok   = we && mine && !busy_q;
  assign wr_ctrl = wr_ok && (addr == 16'h0000);
  assign wr_idx  = wr_ok && (addr == VND_IDX);
  assign wr_win  = wr_ok && (addr == VND_WIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST[WORD_W-2:0];
      idx_q  <= '0;
      busy_q <= 1'b0;
      rcnt_q <= '0;
    end else if (busy_q) begin
      ctrl_q <= CTRL_RST[WORD_W-2:0];
      idx_q  <= '0;
      if (rcnt_q == '0) busy_q <= 1'b0;
      else              rcnt_q <= rcnt_q - 1'b1;
    end else begin
      if (wr_ctrl && wdata[WORD_W-1]) begin
        busy_q <= 1'b1;
        rcnt_q <= RC_W'(RST_CYCLES - 1);
        ctrl_q <= CTRL_RST[WORD_W-2:0];
        idx_q  <= '0;
      end else begin
        if (wr_ctrl) ctrl_q <= wdata[WORD_W-2:0];
        if (wr_idx)  idx_q  <= wdata[IDX_W-1:0];
      end
    end
  end

  for (genvar g = 0; g < NSC; g++) begin : g_sc
    logic [WORD_W-1:0] cell_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                       cell_q <= '0;
      else if (busy_q || (wr_ctrl && wdata[WORD_W-1])) cell_q <= '0;
      else if (wr_win && idx_q == IDX_W'(g))           cell_q <= wdata;
    end
    assign bank_w[g] = cell_q;
  end

  always_comb begin
    rdata = '0;
    if (mine) begin
      if (addr == 16'h0000)     rdata = {busy_q, ctrl_q};
      else if (addr == 16'h0001) rdata = ID_WORD;
      else if (addr == VND_IDX)  rdata = WORD_W'(idx_q);
      else if (addr == VND_WIN)  rdata = bank_w[idx_q];
    end
  end

  assert_unimpl_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mine |-> (rdata == '0));
  assert_rst_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && rcnt_q == '0) |=> !busy_q);
  assert_rst_defaults_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> (idx_q == '0 && ctrl_q == CTRL_RST[WORD_W-2:0]));
endmodule

// File: rtl/mgmt_regdev.sv
module mgmt_regdev
  import mgmt_pkg::*;
#(
  parameter int                PRE_LEN    = 32,
  parameter int                IDX_W      = 3,
  parameter int                RST_CYCLES = 8,
  parameter logic [WORD_W-1:0] ID_WORD    = 16'h2A5C,
  parameter logic [WORD_W-1:0] CTRL_RST   = 16'h1040,
  parameter logic [DEV_W-1:0]  MY_DEV     = 5'd1,
  parameter logic [WORD_W-1:0] VND_IDX    = 16'h8000,
  parameter logic [WORD_W-1:0] VND_WIN    = 16'h8001
) (
  input  logic        mdc,
  input  logic        rst_n,
  input  logic [4:0]  my_port,
  input  logic        md_in,
  output logic        md_out,
  output logic        md_oe
);
  logic [DEV_W-1:0]  cur_dev;
  logic              ptr_load, ptr_inc, reg_we;
  logic [WORD_W-1:0] wdata, rdata, ptr;

  mgmt_frame_rx #(.PRE_LEN(PRE_LEN)) u_rx (
    .clk(mdc), .rst_n(rst_n), .md_in(md_in), .my_port(my_port),
    .rdata(rdata), .cur_dev(cur_dev), .ptr_load(ptr_load),
    .ptr_inc(ptr_inc), .reg_we(reg_we), .wdata(wdata),
    .md_out(md_out), .md_oe(md_oe)
  );

  mgmt_addr_ptrs u_ptrs (
    .clk(mdc), .rst_n(rst_n), .dev(cur_dev), .load(ptr_load),
    .inc(ptr_inc), .load_val(wdata), .ptr(ptr)
  );

  mgmt_reg_bank #(
    .IDX_W(IDX_W), .RST_CYCLES(RST_CYCLES), .ID_WORD(ID_WORD),
    .CTRL_RST(CTRL_RST), .MY_DEV(MY_DEV), .VND_IDX(VND_IDX), .VND_WIN(VND_WIN)
  ) u_bank (
    .clk(mdc), .rst_n(rst_n), .dev(cur_dev), .addr(ptr), .we(reg_we),
    .wdata(wdata), .rdata(rdata)
  );

  assert_no_write_on_read_R5: assert property (@(posedge mdc) disable iff (!rst_n)
    md_oe |-> !reg_we);
endmodule

// File: tb/mgmt_regdev_tb.sv
module mgmt_regdev_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic md_in = 1'b1;
  logic [4:0] my_port = 5'd3;
  logic md_out, md_oe;
  int total = 0, bad = 0;
  bit done = 0;

  localparam logic [1:0] A = 2'b00, W = 2'b01, RI = 2'b10, RD = 2'b11;

  always #5 clk = ~clk;

  mgmt_regdev #(.RST_CYCLES(100)) dut_i (
    .mdc(clk), .rst_n(rst_n), .my_port(my_port), .md_in(md_in),
    .md_out(md_out), .md_oe(md_oe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic frame(input logic [1:0] op, input logic [4:0] port, input logic [4:0] dev,
                       input logic [15:0] data, input int pre,
                       output logic [15:0] rd, output bit ta_ok, output bit drove);
    logic [13:0] hb;
    bit o14, o15, v15, oa;
    hb = {2'b00, op, port, dev};
    rd = '0; drove = 0;
    if (pre < 32) begin @(negedge clk); md_in = 1'b0; end
    for (int i = 0; i < pre; i++) begin @(negedge clk); md_in = 1'b1; end
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      if (md_oe) drove = 1;
      if (k == 14) o14 = md_oe;
      if (k == 15) begin o15 = md_oe; v15 = md_out; end
      if (k >= 16) rd[31-k] = md_out;
      if (k < 14) md_in = hb[13-k];
      else if (op[1]) md_in = 1'b1;
      else if (k == 14) md_in = 1'b1;
      else if (k == 15) md_in = 1'b0;
      else md_in = data[31-k];
    end
    @(negedge clk);
    oa = md_oe;
    if (md_oe) drove = 1;
    md_in = 1'b1;
    ta_ok = !o14 && o15 && !v15 && !oa;
  endtask

  task automatic op1(input logic [1:0] op, input logic [4:0] dev, input logic [15:0] d);
    logic [15:0] r; bit t, dr;
    frame(op, 5'd3, dev, d, 32, r, t, dr);
  endtask

  task automatic rd_chk(input logic [1:0] op, input logic [4:0] dev,
                        input logic [15:0] exp, input string tag);
    logic [15:0] r; bit t, dr;
    frame(op, 5'd3, dev, 16'h0, 32, r, t, dr);
    chk(r == exp, tag, r, exp);
  endtask

  task automatic t_reset;
    chk(md_oe == 1'b0, "R11 oe after reset", md_oe, 0);
    rd_chk(RD, 5'd1, 16'h1040, "R11 ctrl default at pointer 0");
    op1(A, 5'd1, 16'h8000);
    rd_chk(RD, 5'd1, 16'h0000, "R11 bank select default");
  endtask

  task automatic t_rw;
    logic [15:0] r; bit t, dr;
    op1(A, 5'd1, 16'h0000);
    op1(W, 5'd1, 16'h0ABC);
    frame(RD, 5'd3, 5'd1, 16'h0, 32, r, t, dr);
    chk(r == 16'h0ABC, "R2 write then read ctrl", r, 16'h0ABC);
    chk(t, "R4 turnaround release then zero", t, 1);
    rd_chk(RD, 5'd1, 16'h0ABC, "R5 read keeps pointer");
  endtask

  task automatic t_unimpl;
    op1(A, 5'd1, 16'h0001);
    op1(W, 5'd1, 16'hFFFF);
    rd_chk(RD, 5'd1, 16'h2A5C, "R7 identifier read-only");
    op1(A, 5'd1, 16'h0005);
    op1(W, 5'd1, 16'hBEEF);
    rd_chk(RD, 5'd1, 16'h0000, "R7 unimplemented address zero");
    op1(A, 5'd7, 16'h0000);
    op1(W, 5'd7, 16'h1234);
    rd_chk(RD, 5'd7, 16'h0000, "R7 other device zero");
  endtask

  task automatic t_port;
    logic [15:0] r; bit t, dr;
    op1(A, 5'd1, 16'h0000);
    frame(A, 5'd4, 5'd1, 16'h0001, 32, r, t, dr);
    frame(W, 5'd4, 5'd1, 16'h0111, 32, r, t, dr);
    frame(RD, 5'd4, 5'd1, 16'h0, 32, r, t, dr);
    chk(!dr, "R3 mismatched port never drives", dr, 0);
    rd_chk(RD, 5'd1, 16'h0ABC, "R3 mismatched port no effect");
  endtask

  task automatic t_pre;
    logic [15:0] r; bit t, dr;
    frame(W, 5'd3, 5'd1, 16'h1234, 31, r, t, dr);
    rd_chk(RD, 5'd1, 16'h0ABC, "R1 short preamble ignored");
  endtask

  task automatic t_window;
    op1(A, 5'd1, 16'h8000); op1(W, 5'd1, 16'hFFFA);
    rd_chk(RD, 5'd1, 16'h0002, "R9 bank select keeps low bits");
    op1(A, 5'd1, 16'h8001); op1(W, 5'd1, 16'h1111);
    op1(A, 5'd1, 16'h8000); op1(W, 5'd1, 16'h0005);
    op1(A, 5'd1, 16'h8001); op1(W, 5'd1, 16'h5555);
    rd_chk(RD, 5'd1, 16'h5555, "R9 window bank 5");
    op1(A, 5'd1, 16'h8000); op1(W, 5'd1, 16'h0002);
    op1(A, 5'd1, 16'h8001);
    rd_chk(RD, 5'd1, 16'h1111, "R9 window bank 2");
  endtask

  task automatic t_inc;
    op1(A, 5'd1, 16'h8000);
    rd_chk(RI, 5'd1, 16'h0002, "R6 read-inc data");
    rd_chk(RD, 5'd1, 16'h1111, "R6 pointer advanced to window");
    op1(A, 5'd1, 16'hFFFF);
    rd_chk(RI, 5'd1, 16'h0000, "R6 read-inc at top");
    rd_chk(RD, 5'd1, 16'h0ABC, "R6 pointer wrapped to zero");
  endtask

  task automatic t_ptrs;
    op1(A, 5'd1, 16'h0001);
    op1(A, 5'd2, 16'h0000);
    rd_chk(RD, 5'd1, 16'h2A5C, "R8 device pointers independent");
  endtask

  task automatic t_softrst;
    op1(A, 5'd1, 16'h8000); op1(W, 5'd1, 16'h0005);
    op1(A, 5'd1, 16'h0000);
    op1(W, 5'd1, 16'h8000);
    rd_chk(RD, 5'd1, 16'h9040, "R10 bit15 set while resetting");
    md_in = 1'b1;
    repeat (110) @(negedge clk);
    rd_chk(RD, 5'd1, 16'h1040, "R10 bit15 cleared and ctrl default");
    op1(A, 5'd1, 16'h8000);
    rd_chk(RD, 5'd1, 16'h0000, "R10 bank select cleared");
    op1(W, 5'd1, 16'h0005);
    op1(A, 5'd1, 16'h8001);
    rd_chk(RD, 5'd1, 16'h0000, "R10 subcarrier register cleared");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_rw;
    t_unimpl;
    t_port;
    t_pre;
    t_window;
    t_inc;
    t_ptrs;
    t_softrst;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule